// File: doc/BRIEF.md
# Persist Ordering Queue

This block sits beside a core's load-store queue and holds the persistence-ordering operations of one thread in program order: cache-line flush requests, ordering barriers, strand-start markers and strand-merge markers. It decides when each flush, barrier or strand-start may move on to the strand buffer unit, always in queue order, and when a younger store in the store queue may issue.

Two strengths of ordering are enforced. A barrier is light. Stores older than the barrier must issue before any flush younger than it. Flushes older than the barrier must have been sent onward, though not yet completed, before any store younger than it may issue. A merge marker is heavy. It is never sent onward. It completes only once every older queue entry has completed and left, and the store queue reports that every older store has completed. Until then it holds back every younger forward and every younger store.

Each operation receives a tag, which is the running allocation count modulo 2^(log2(DEPTH)+2). A store is tagged with the current `tail_tag` value when it is dispatched. This makes the store younger than every queue entry whose tag is below its own. DEPTH must be a power of two.

Top module: `persist_order_queue`

## Requirements
- R1: After reset the queue is empty: `fwd_valid`=0, `alloc_full`=0, `st_permit`=1, `head_tag`=`tail_tag`=0.
- R2: `alloc_full` is 1 exactly when DEPTH entries are held. An allocation attempted while full is dropped and `tail_tag` does not advance. Otherwise each accepted allocation advances `tail_tag` by one.
- R3: Operation codes are 0 flush, 1 barrier, 2 strand-start and 3 merge. The forward port offers the oldest entry that has not yet been sent, and only that entry, together with its code, its address and its slot index (tag mod DEPTH). The entry counts as sent on a cycle where `fwd_valid` and `fwd_ready` are both 1.
- R4: When a flush is allocated, it captures `sq_hit_mask`, which marks the older unissued stores to its address. It is not offered until every captured slot has been seen with its `sq_issued` bit at 1.
- R5: When a barrier is allocated, it captures `sq_unissued_mask`. It is not offered until all of those stores have issued, and so no younger flush can be offered before them.
- R6: `st_permit` for the store tagged `st_tag` is 0 while an older barrier has an unsent flush older than itself. It becomes 1 as soon as those flushes are sent, without waiting for their completion.
- R7: A merge entry is never offered on the forward port. While it is present, no younger entry is offered.
- R8: A merge entry completes only when it is at the head and `sq_older_drained` is 1. Until then `st_permit` is 0 for every store younger than it.
- R9: A completion acknowledge (`cmp_valid`, `cmp_idx`) marks a sent entry complete. Entries leave from the head only, at most one per cycle, and only once complete. The head leaves on the edge after its completion.
- R10: A strand-start entry depends on no store. It is offered as soon as every older entry has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate one operation |
| alloc_op | input | 2 | Operation code of the allocation |
| alloc_addr | input | PQ_AW | Line address of a flush |
| alloc_full | output | 1 | Queue holds DEPTH entries |
| tail_tag | output | log2(DEPTH)+2 | Tag the next allocation will receive; tag given to stores at dispatch |
| head_tag | output | log2(DEPTH)+2 | Tag of the oldest entry; store queue uses it to judge older stores |
| sq_hit_mask | input | PQ_SQN | Store slots with unissued stores to `alloc_addr` |
| sq_unissued_mask | input | PQ_SQN | Store slots with unissued stores |
| sq_issued | input | PQ_SQN | Store slots whose store has issued |
| sq_older_drained | input | 1 | All stores older than `head_tag` have completed |
| st_tag | input | log2(DEPTH)+2 | Tag of the store asking to issue |
| st_permit | output | 1 | That store may issue |
| fwd_valid | output | 1 | An entry is offered to the strand buffer unit |
| fwd_ready | input | 1 | Strand buffer unit takes the offer |
| fwd_op | output | 2 | Code of the offered entry |
| fwd_addr | output | PQ_AW | Address of the offered entry |
| fwd_idx | output | log2(DEPTH) | Slot index of the offered entry |
| cmp_valid | input | 1 | Completion acknowledge |
| cmp_idx | input | log2(DEPTH) | Slot index being acknowledged |

## Verification
The bench targets four situations:
- A store gated by a barrier while an older flush is still unsent. A design that waited for flush completion rather than issue would keep `st_permit` low for too long.
- A flush or barrier whose captured store slots issue late. A design that ignored the captured mask would forward the flush early.
- A merge marker with younger work queued behind it while the store queue has not drained. A design that treated the merge like a barrier would leak younger forwards or store permits.
- A completion acknowledge that arrives for an entry that is not at the head. Early retirement would then show up as a wrong `head_tag`.

Filling the queue checks that an allocation attempted while full does not advance the tail.

// File: rtl/pq_pkg.sv
package pq_pkg;

    localparam int PQ_DEPTH = 16;
    localparam int PQ_AW    = 32;
    localparam int PQ_SQN   = 8;

    typedef enum logic [1:0] {
        OP_FLUSH     = 2'd0,
        OP_BARRIER   = 2'd1,
        OP_NEWSTRAND = 2'd2,
        OP_JOIN      = 2'd3
    } pq_op_e;

    typedef struct packed {
        logic              valid;
        pq_op_e            op;
        logic [PQ_AW-1:0]  addr;
        logic [PQ_SQN-1:0] wait_mask;
        logic              issued;
        logic              done;
    } pq_ent_t;

    // Store slots an operation must see issued before it may be forwarded.
    // Flush: same-address older stores (R4). Barrier: all older stores (R5).
    function automatic logic [PQ_SQN-1:0] capture_mask(
        input pq_op_e            op,
        input logic [PQ_SQN-1:0] hit,
        input logic [PQ_SQN-1:0] unissued
    );
        case (op)
            OP_FLUSH:   return hit;
            OP_BARRIER: return unissued;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/pq_slot.sv
module pq_slot
    import pq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  pq_ent_t           wr_ent,
    input  logic              fire_en,
    input  logic              cmp_en,
    input  logic              join_en,
    input  logic              clr_en,
    input  logic [PQ_SQN-1:0] sq_issued,
    output pq_ent_t           ent
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (wr_en) begin
            ent <= wr_ent;
        end else begin
            if (clr_en)
                ent.valid <= 1'b0;
            if (fire_en)
                ent.issued <= 1'b1;
            if ((cmp_en && ent.issued) || join_en)
                ent.done <= 1'b1;
            ent.wait_mask <= ent.wait_mask & ~sq_issued;
        end
    end

    AST_FLUSH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (ent.valid && ent.wait_mask != '0) |-> !fire_en); // R4

endmodule

// File: rtl/pq_scan.sv
module pq_scan
    import pq_pkg::*;
#(
    parameter int DEPTH = PQ_DEPTH,
    parameter int IW    = $clog2(DEPTH),
    parameter int SW    = IW + 2
) (
    input  pq_ent_t [DEPTH-1:0] ents,
    input  logic [IW-1:0]       head_slot,
    input  logic [SW-1:0]       count,
    input  logic [SW-1:0]       st_dist,
    output logic                found,
    output logic [IW-1:0]       off,
    output logic                permit
);

    logic          blk;
    logic          pend_flush;
    logic [IW-1:0] idx;
    pq_ent_t       e;

    // Walk the queue oldest-first from the head.
    always_comb begin
        found      = 1'b0;
        off        = '0;
        blk        = 1'b0;
        pend_flush = 1'b0;
        idx        = '0;
        e          = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_slot + IW'(k);
            e   = ents[idx];
            if (SW'(k) < count) begin
                if (SW'(k) < st_dist) begin
                    if (e.op == OP_JOIN && !e.done)
                        blk = 1'b1;
                    if (e.op == OP_BARRIER && pend_flush)
                        blk = 1'b1;
                end
                if (e.op == OP_FLUSH && !e.issued)
                    pend_flush = 1'b1;
                if (!found && !e.issued) begin
                    found = 1'b1;
                    off   = IW'(k);
                end
            end
        end
        permit = (st_dist > count) || !blk;
    end

endmodule

// File: rtl/persist_order_queue.sv
module persist_order_queue
    import pq_pkg::*;
#(
    parameter int DEPTH = PQ_DEPTH,
    localparam int IW   = $clog2(DEPTH),
    localparam int SW   = IW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_op,
    input  logic [PQ_AW-1:0]  alloc_addr,
    output logic              alloc_full,
    output logic [SW-1:0]     tail_tag,
    output logic [SW-1:0]     head_tag,
    input  logic [PQ_SQN-1:0] sq_hit_mask,
    input  logic [PQ_SQN-1:0] sq_unissued_mask,
    input  logic [PQ_SQN-1:0] sq_issued,
    input  logic              sq_older_drained,
    input  logic [SW-1:0]     st_tag,
    output logic              st_permit,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [1:0]        fwd_op,
    output logic [PQ_AW-1:0]  fwd_addr,
    output logic [IW-1:0]     fwd_idx,
    input  logic              cmp_valid,
    input  logic [IW-1:0]     cmp_idx
);

    logic [SW-1:0]       head_q, tail_q, count, st_dist;
    logic [IW-1:0]       head_slot, tail_slot, scan_off;
    logic                nonempty, alloc_we, retire, join_fin, fire, scan_found;
    pq_ent_t [DEPTH-1:0] ents;
    pq_ent_t             head_ent, cand, new_ent;
    pq_op_e              in_op;

    assign count      = tail_q - head_q;
    assign nonempty   = (count != '0);
    assign alloc_full = (count == SW'(DEPTH));
    assign head_slot  = head_q[IW-1:0];
    assign tail_slot  = tail_q[IW-1:0];
    assign head_tag   = head_q;
    assign tail_tag   = tail_q;
    assign st_dist    = st_tag - head_q;
    assign head_ent   = ents[head_slot];

    assign retire   = nonempty && head_ent.valid && head_ent.done;
    assign join_fin = nonempty && head_ent.valid && head_ent.op == OP_JOIN
                      && !head_ent.done && sq_older_drained;

    pq_scan #(.DEPTH(DEPTH), .IW(IW), .SW(SW)) u_scan (
        .ents      (ents),
        .head_slot (head_slot),
        .count     (count),
        .st_dist   (st_dist),
        .found     (scan_found),
        .off       (scan_off),
        .permit    (st_permit)
    );

    assign fwd_idx   = head_slot + scan_off;
    assign cand      = ents[fwd_idx];
    assign fwd_valid = scan_found && cand.op != OP_JOIN && cand.wait_mask == '0;
    assign fwd_op    = cand.op;
    assign fwd_addr  = cand.addr;
    assign fire      = fwd_valid && fwd_ready;

    assign in_op    = pq_op_e'(alloc_op);
    assign alloc_we = alloc_valid && !alloc_full;

    always_comb begin
        new_ent           = '0;
        new_ent.valid     = 1'b1;
        new_ent.op        = in_op;
        new_ent.addr      = alloc_addr;
        new_ent.wait_mask = capture_mask(in_op, sq_hit_mask, sq_unissued_mask) & ~sq_issued;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        pq_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (alloc_we && tail_slot == IW'(g)),
            .wr_ent    (new_ent),
            .fire_en   (fire && fwd_idx == IW'(g)),
            .cmp_en    (cmp_valid && cmp_idx == IW'(g)),
            .join_en   (join_fin && head_slot == IW'(g)),
            .clr_en    (retire && head_slot == IW'(g)),
            .sq_issued (sq_issued),
            .ent       (ents[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc_we)
                tail_q <= tail_q + 1'b1;
            if (retire)
                head_q <= head_q + 1'b1;
        end
    end

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        (alloc_full && alloc_valid) |=> tail_q == $past(tail_q)); // R2
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count <= SW'(DEPTH)); // R2
    AST_FWD_FRESH: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> !cand.issued); // R3
    AST_JOIN_HOLDS_FWD: assert property (@(posedge clk) disable iff (rst)
        (nonempty && head_ent.op == OP_JOIN) |-> !fwd_valid); // R7
    AST_JOIN_HOLDS_STORE: assert property (@(posedge clk) disable iff (rst)
        (nonempty && head_ent.op == OP_JOIN && !head_ent.done && st_tag == tail_q)
        |-> !st_permit); // R8
    AST_HEAD_WAITS: assert property (@(posedge clk) disable iff (rst)
        (nonempty && !head_ent.done) |=> head_q == $past(head_q)); // R9

endmodule

// File: tb/tb_persist_order_queue.sv
`timescale 1ns/1ps
module tb_persist_order_queue;
    import pq_pkg::*;

    localparam int DEPTH = PQ_DEPTH;
    localparam int IW    = $clog2(DEPTH);
    localparam int SW    = IW + 2;
    localparam int MOD   = 1 << SW;
    localparam int SQN   = PQ_SQN;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst;
    logic              alloc_valid, fwd_ready, cmp_valid, sq_older_drained;
    logic [1:0]        alloc_op;
    logic [PQ_AW-1:0]  alloc_addr;
    logic [IW-1:0]     cmp_idx;
    logic [SQN-1:0]    hit_v, unis_v, iss_v;
    logic [SW-1:0]     st_tag_d;
    logic              alloc_full, st_permit, fwd_valid;
    logic [SW-1:0]     tail_tag, head_tag;
    logic [1:0]        fwd_op;
    logic [PQ_AW-1:0]  fwd_addr;
    logic [IW-1:0]     fwd_idx;
    int                st_abs;

    bit sqv [SQN];
    bit sqi [SQN];
    int sqa [SQN];

    always_comb begin
        hit_v  = '0;
        unis_v = '0;
        iss_v  = '0;
        for (int s = 0; s < SQN; s++) begin
            if (sqv[s]) begin
                if (sqi[s]) iss_v[s] = 1'b1;
                else begin
                    unis_v[s] = 1'b1;
                    if (sqa[s] == int'(alloc_addr)) hit_v[s] = 1'b1;
                end
            end
        end
    end
    assign st_tag_d = st_abs[SW-1:0];

    persist_order_queue #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_addr(alloc_addr),
        .alloc_full(alloc_full), .tail_tag(tail_tag), .head_tag(head_tag),
        .sq_hit_mask(hit_v), .sq_unissued_mask(unis_v), .sq_issued(iss_v),
        .sq_older_drained(sq_older_drained),
        .st_tag(st_tag_d), .st_permit(st_permit),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_op(fwd_op),
        .fwd_addr(fwd_addr), .fwd_idx(fwd_idx),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx)
    );

    // Behavioural reference model
    typedef struct {
        int             op;
        int             addr;
        int             tag;
        logic [SQN-1:0] mask;
        bit             issued;
        bit             done;
    } m_ent_t;
    m_ent_t mq[$];
    int     alloc_count = 0;

    int  nchk = 0;
    int  nfail = 0;
    bit  finished = 0;

    task automatic check(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_fwd(output bit v, output int op, output int addr,
                             output int slot, output int mi);
        v = 0; op = 0; addr = 0; slot = 0; mi = 0;
        for (int i = 0; i < mq.size(); i++) begin
            if (!mq[i].issued) begin
                if (mq[i].op != 3 && mq[i].mask == '0) begin
                    v = 1; op = mq[i].op; addr = mq[i].addr;
                    slot = mq[i].tag % DEPTH; mi = i;
                end
                break;
            end
        end
    endtask

    function automatic bit model_permit(int st);
        bit pend = 0;
        for (int i = 0; i < mq.size(); i++) begin
            if (mq[i].tag < st) begin
                if (mq[i].op == 3 && !mq[i].done) return 0;
                if (mq[i].op == 1 && pend) return 0;
            end
            if (mq[i].op == 0 && !mq[i].issued) pend = 1;
        end
        return 1;
    endfunction

    task automatic tick();
        bit mv, mp, full_pre, ret;
        int mop, maddr, mslot, mi;
        m_ent_t ne;
        #0.5;
        model_fwd(mv, mop, maddr, mslot, mi);
        mp = model_permit(st_abs);
        check("R3", "fwd_valid", int'(fwd_valid), int'(mv));
        if (mv && fwd_valid) begin
            check("R3", "fwd_op", int'(fwd_op), mop);
            check("R3", "fwd_addr", int'(fwd_addr), maddr);
            check("R3", "fwd_idx", int'(fwd_idx), mslot);
        end
        check("R6", "st_permit", int'(st_permit), int'(mp));
        check("R2", "alloc_full", int'(alloc_full), int'(mq.size() == DEPTH));
        check("R9", "head_tag", int'(head_tag),
              (mq.size() > 0 ? mq[0].tag : alloc_count) % MOD);
        check("R2", "tail_tag", int'(tail_tag), alloc_count % MOD);
        full_pre = (mq.size() == DEPTH);
        ret = (mq.size() > 0) && mq[0].done;
        if (mv && fwd_ready) mq[mi].issued = 1;
        if (cmp_valid)
            for (int i = 0; i < mq.size(); i++)
                if ((mq[i].tag % DEPTH) == int'(cmp_idx) && mq[i].issued && mq[i].op != 3)
                    mq[i].done = 1;
        if (mq.size() > 0 && mq[0].op == 3 && !mq[0].done && sq_older_drained)
            mq[0].done = 1;
        for (int i = 0; i < mq.size(); i++) mq[i].mask = mq[i].mask & ~iss_v;
        if (ret) void'(mq.pop_front());
        if (alloc_valid && !full_pre) begin
            ne.op = int'(alloc_op);
            ne.addr = int'(alloc_addr);
            ne.tag = alloc_count;
            ne.mask = (ne.op == 0 ? hit_v : (ne.op == 1 ? unis_v : '0)) & ~iss_v;
            ne.issued = 0;
            ne.done = 0;
            mq.push_back(ne);
            alloc_count++;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #0.2;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    task automatic rand_step();
        int s, r;
        int cands[$];
        s = $urandom % SQN;
        if (sqv[s] && sqi[s] && ($urandom % 4 == 0)) begin sqv[s] = 0; sqi[s] = 0; end
        s = $urandom % SQN;
        if (sqv[s] && !sqi[s] && ($urandom % 3 == 0)) sqi[s] = 1;
        s = $urandom % SQN;
        if (!sqv[s] && ($urandom % 3 == 0)) begin sqv[s] = 1; sqi[s] = 0; sqa[s] = $urandom % 4; end
        alloc_valid = ($urandom % 2 == 0);
        r = $urandom % 10;
        alloc_op = (r < 5) ? 2'd0 : (r < 7) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
        alloc_addr = PQ_AW'($urandom % 4);
        fwd_ready = ($urandom % 4 != 0);
        sq_older_drained = ($urandom % 4 == 0);
        for (int i = 0; i < mq.size(); i++)
            if (mq[i].issued && !mq[i].done && mq[i].op != 3) cands.push_back(mq[i].tag % DEPTH);
        cmp_valid = 0;
        cmp_idx = '0;
        if (cands.size() > 0 && ($urandom % 2 == 0)) begin
            cmp_valid = 1;
            cmp_idx = IW'(cands[$urandom % cands.size()]);
        end
        st_abs = alloc_count - int'($urandom % 6);
        if (st_abs < 0) st_abs = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog actual=1 expected=0");
        report();
    end

    initial begin
        rst = 1; alloc_valid = 0; alloc_op = 0; alloc_addr = '0;
        fwd_ready = 0; cmp_valid = 0; cmp_idx = '0; sq_older_drained = 0; st_abs = 0;
        for (int s = 0; s < SQN; s++) begin sqv[s] = 0; sqi[s] = 0; sqa[s] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        settle();
        check("R1", "reset fwd_valid", int'(fwd_valid), 0);
        check("R1", "reset alloc_full", int'(alloc_full), 0);
        check("R1", "reset st_permit", int'(st_permit), 1);
        check("R1", "reset head_tag", int'(head_tag), 0);
        check("R1", "reset tail_tag", int'(tail_tag), 0);

        // R10: strand-start forwards while a store is still unissued
        sqv[0] = 1; sqi[0] = 0; sqa[0] = 1;
        alloc_valid = 1; alloc_op = 2; alloc_addr = '0; tick(); alloc_valid = 0;
        check("R10", "newstrand offered", int'(fwd_valid && fwd_op == 2), 1);
        fwd_ready = 1; tick(); fwd_ready = 0;
        cmp_valid = 1; cmp_idx = 0; tick(); cmp_valid = 0; tick();
        check("R9", "head after retire", int'(head_tag), 1);

        // R5: barrier waits for older unissued store
        alloc_valid = 1; alloc_op = 1; tick(); alloc_valid = 0;
        check("R5", "barrier held", int'(fwd_valid), 0);
        sqi[0] = 1; tick();
        check("R5", "barrier released", int'(fwd_valid && fwd_op == 1), 1);
        fwd_ready = 1; tick(); fwd_ready = 0;
        cmp_valid = 1; cmp_idx = 1; tick(); cmp_valid = 0; tick();

        // R4 and R6: flush waits for same-address store; barrier gates stores
        sqv[1] = 1; sqi[1] = 0; sqa[1] = 2;
        alloc_valid = 1; alloc_op = 0; alloc_addr = 2; tick();
        alloc_op = 1; tick(); alloc_valid = 0;
        st_abs = 4; settle();
        check("R4", "flush held", int'(fwd_valid), 0);
        check("R6", "store blocked", int'(st_permit), 0);
        sqi[1] = 1; tick();
        check("R4", "flush released", int'(fwd_valid && fwd_op == 0 && fwd_addr == 2), 1);
        fwd_ready = 1; tick(); fwd_ready = 0; settle();
        check("R6", "store freed after flush issue", int'(st_permit), 1);
        fwd_ready = 1; tick(); fwd_ready = 0;
        cmp_valid = 1; cmp_idx = 2; tick(); cmp_idx = 3; tick(); cmp_valid = 0; tick(); tick();

        // R7 and R8: merge marker holds younger work
        alloc_valid = 1; alloc_op = 3; tick(); alloc_op = 2; tick(); alloc_valid = 0;
        st_abs = 6; settle();
        check("R7", "join not forwarded", int'(fwd_valid), 0);
        check("R8", "store behind join", int'(st_permit), 0);
        tick(); tick();
        check("R7", "younger held", int'(fwd_valid), 0);
        sq_older_drained = 1; tick(); sq_older_drained = 0; tick();
        check("R7", "younger after join", int'(fwd_valid && fwd_op == 2), 1);
        check("R8", "store after join", int'(st_permit), 1);
        fwd_ready = 1; tick(); fwd_ready = 0;
        cmp_valid = 1; cmp_idx = 5; tick(); cmp_valid = 0; tick();

        // R2: fill the queue, extra allocation is dropped
        alloc_valid = 1; alloc_op = 2; st_abs = alloc_count;
        repeat (DEPTH) tick();
        check("R2", "full flag", int'(alloc_full), 1);
        tick();
        check("R2", "tail held while full", int'(tail_tag), 22 % MOD);
        alloc_valid = 0;

        // Randomised traffic compared against the model every cycle
        for (int c = 0; c < 3000; c++) begin
            rand_step();
            tick();
        end
        report();
    end

endmodule